// File: doc/BRIEF.md
# PWM Timer with Staged Match Updates

This block is a multi-channel pulse-width modulation timer. A free-running counter counts from zero up to the active period value held in match slot 0, then returns to zero. That return is the period event. Each output channel compares the counter against one or two of the remaining match slots to produce a single-edge or double-edge waveform.

Software reaches the block through a plain synchronous write port. Writes to a match slot never touch the running waveform directly. They land in a shadow copy. A shadow value moves into the active slot only when two things are true: its bit in the commit-request register is set, and a period event occurs. All commit-request bits clear themselves at that event. Because of this, several slots, such as both edges of a double-edge channel, can be staged in any order and then switched in the same period boundary. Separate registers select the output enables and the double-edge modes.

Top module: `pwm_shadow_timer`

## Requirements
- R1: A write to address i, for i below NUM_MATCH, stores wr_data in shadow slot i. It has no effect on count or pwm_out until that slot is committed.
- R2: Address NUM_MATCH is the commit-request register. Bit i of it requests slot i. A write replaces the whole register. It resets to all zeros, and only slots whose bit is set are committed.
- R3: A period event is a cycle in which count equals active slot 0. At that event, every requested slot copies its shadow value into its active value. The new values govern from the next cycle, which is count 0 of the new period.
- R4: Every commit-request bit is zero after a period event, so later shadow writes need a new request.
- R5: A shadow write with no request bit set stays without effect across any number of period events.
- R6: count rises by one per cycle and returns to 0 after a period event. A period therefore lasts active slot 0 plus one cycles.
- R7: Channel k, for k of 1 or more, in double-edge mode goes high in the cycle after count equals slot k and low in the cycle after count equals slot k+1. Both edges staged and requested in one write change in the same period.
- R8: Channel k in single-edge mode is high from count 0 and goes low in the cycle after count equals slot k+1. If setting and clearing coincide, setting wins, so a slot value at or above the period value keeps the channel high for the whole period.
- R9: Address NUM_MATCH+1 holds the output enables, bit k for channel k, reset 0. A cleared bit holds pwm_out[k] low. Address NUM_MATCH+2 holds the double-edge selects, bit k for channel k. Bit 0 is ignored, so channel 0 is always single-edge.
- R10: A request write or shadow write in the same cycle as a period event is applied before the commit. The new value takes effect for the period that starts next.
- R11: After reset, count is 0, all active and shadow slots are 0, and pwm_out is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| pwm_out | output | NUM_MATCH-1 | Channel outputs |
| count | output | CNT_W | Current timer count |

## Verification
The critical coincidence is a register write landing in the same cycle as the period event. The bench waits until count equals the active period value and issues the commit-request write at that edge. It then judges the outcome by the duty of the very next period, and by a later unrequested write that must stay without effect. The second coincidence is the pair of edge slots of a double-edge channel. They are staged in reverse order and committed by one write, and the bench checks that both the rise and fall positions move in the first new period.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;

  typedef enum logic [2:0] {
    RK_MATCH,
    RK_LATCH,
    RK_ENABLE,
    RK_MODE,
    RK_NONE
  } reg_kind_e;

  // Address map is derived from the number of match slots.
  function automatic reg_kind_e decode_addr(input int unsigned addr,
                                            input int unsigned n_match);
    if (addr < n_match)          return RK_MATCH;
    else if (addr == n_match)    return RK_LATCH;
    else if (addr == n_match + 1) return RK_ENABLE;
    else if (addr == n_match + 2) return RK_MODE;
    else                         return RK_NONE;
  endfunction

  // Next state of a set/clear output flop; set has priority (R8).
  function automatic logic edge_step(input logic q, input logic set_e,
                                     input logic clr_e);
    if (set_e) return 1'b1;
    if (clr_e) return 1'b0;
    return q;
  endfunction

endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_top,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);

  assign wrap_evt = (cnt == period_top);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (wrap_evt) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> cnt == $past(cnt) + 1'b1);  // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= period_top);  // R6

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
  parameter int NUM_MATCH = 4,
  parameter int CNT_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_MATCH-1:0] val_wr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 latch_wr,
  input  logic [NUM_MATCH-1:0] latch_data,
  input  logic                 commit_evt,
  output logic [CNT_W-1:0]     active [NUM_MATCH]
);

  logic [CNT_W-1:0]     shadow     [NUM_MATCH];
  logic [CNT_W-1:0]     shadow_eff [NUM_MATCH];
  logic [NUM_MATCH-1:0] latch_q;
  logic [NUM_MATCH-1:0] latch_eff;
  logic [NUM_MATCH-1:0] xfer;

  // A request written on the event cycle counts before the commit (R10).
  assign latch_eff = latch_wr ? latch_data : latch_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          latch_q <= '0;
    else if (commit_evt) latch_q <= '0;   // self-clearing (R4)
    else                 latch_q <= latch_eff;
  end

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_slot
    assign shadow_eff[i] = val_wr[i] ? wr_data : shadow[i];
    assign xfer[i]       = commit_evt & latch_eff[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end else begin
        shadow[i] <= shadow_eff[i];
        if (xfer[i]) active[i] <= shadow_eff[i];
      end
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_evt |=> $stable(active[i]));  // R5

    AST_SLOT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_evt && latch_eff[i]) |=> active[i] == $past(shadow_eff[i]));  // R3
  end

  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> latch_q == '0);  // R4

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int NUM_MATCH = 4,
  parameter int CNT_W     = 16,
  localparam int NUM_CH   = NUM_MATCH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap_evt,
  input  logic [CNT_W-1:0]  active [NUM_MATCH],
  input  logic [NUM_CH-1:0] dbl_sel,
  input  logic [NUM_CH-1:0] ena,
  output logic [NUM_CH-1:0] pwm_out
);
  import pwm_shadow_pkg::*;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic q;
    logic set_e;
    logic clr_e;
    logic hit_lo;
    logic hit_hi;

    assign hit_lo = (cnt == active[k]);
    assign hit_hi = (cnt == active[k+1]);
    assign set_e  = dbl_sel[k] ? hit_lo : wrap_evt;
    assign clr_e  = hit_hi;

    always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= edge_step(q, set_e, clr_e);
    end

    assign pwm_out[k] = q & ena[k];

    AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_evt && !dbl_sel[k]) |=> q);  // R8

    AST_DOUBLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (dbl_sel[k] && hit_hi && !hit_lo) |=> !q);  // R7
  end

endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer #(
  parameter int NUM_MATCH = 4,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 3,
  localparam int NUM_CH   = NUM_MATCH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [NUM_CH-1:0] pwm_out,
  output logic [CNT_W-1:0]  count
);
  import pwm_shadow_pkg::*;

  reg_kind_e            kind;
  logic [NUM_MATCH-1:0] val_wr;
  logic                 latch_wr;
  logic                 ena_wr;
  logic                 mode_wr;
  logic [NUM_CH-1:0]    ena_q;
  logic [NUM_CH-1:0]    dbl_q;
  logic [CNT_W-1:0]     active [NUM_MATCH];
  logic                 period_evt;

  assign kind     = decode_addr(32'(wr_addr), NUM_MATCH);
  assign latch_wr = wr_en && (kind == RK_LATCH);
  assign ena_wr   = wr_en && (kind == RK_ENABLE);
  assign mode_wr  = wr_en && (kind == RK_MODE);

  for (genvar i = 0; i < NUM_MATCH; i++) begin : g_dec
    assign val_wr[i] = wr_en && (kind == RK_MATCH) && (wr_addr == ADDR_W'(i));
  end

  // Enables and modes; channel 0 cannot be double-edge (R9).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q <= '0;
      dbl_q <= '0;
    end else begin
      if (ena_wr)  ena_q <= wr_data[NUM_CH-1:0];
      if (mode_wr) dbl_q <= {wr_data[NUM_CH-1:1], 1'b0};
    end
  end

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_top (active[0]),
    .cnt        (count),
    .wrap_evt   (period_evt)
  );

  pwm_match_bank #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .val_wr     (val_wr),
    .wr_data    (wr_data),
    .latch_wr   (latch_wr),
    .latch_data (wr_data[NUM_MATCH-1:0]),
    .commit_evt (period_evt),
    .active     (active)
  );

  pwm_edge_gen #(.NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (count),
    .wrap_evt (period_evt),
    .active   (active),
    .dbl_sel  (dbl_q),
    .ena      (ena_q),
    .pwm_out  (pwm_out)
  );

  AST_MODE_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !dbl_q[0]);  // R9

  AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> count == '0);  // R6

endmodule

// File: tb/pwm_shadow_timer_bench.sv
module pwm_shadow_timer_bench;

  localparam int NM = 4;
  localparam int CW = 16;
  localparam int AW = 3;
  localparam int A_LATCH = NM;
  localparam int A_ENA   = NM + 1;
  localparam int A_MODE  = NM + 2;

  // m0, m1, m2, m3, mode, period, high0, high1, high2
  localparam int VEC [4][9] = '{
    '{ 9, 2, 5,  7, 0, 10, 3, 6, 8},
    '{15, 3, 8, 12, 2, 16, 4, 5, 13},
    '{11, 2, 6, 10, 6, 12, 3, 4, 4},
    '{ 7, 9, 7,  0, 0,  8, 8, 8, 1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NM-2:0] pwm_out;
  logic [CW-1:0] count;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pwm_shadow_timer #(.NUM_MATCH(NM), .CNT_W(CW), .ADDR_W(AW)) u_pwm_shadow_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out),
    .count   (count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = AW'(a);
    wr_data = CW'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic to_zero();
    while (count != 0) @(negedge clk);
  endtask

  task automatic next_zero();
    do @(negedge clk); while (count != 0);
  endtask

  // Starts at count 0, walks one period, returns at the next count 0.
  task automatic measure(output int n, output int h0, output int h1,
                         output int h2, output int rise, output int fall);
    logic prev;
    n = 0; h0 = 0; h1 = 0; h2 = 0; rise = -1; fall = -1;
    prev = pwm_out[1];
    do begin
      if (pwm_out[0]) h0++;
      if (pwm_out[1]) h1++;
      if (pwm_out[2]) h2++;
      if (pwm_out[1] && !prev && rise < 0) rise = int'(count);
      if (!pwm_out[1] && prev && fall < 0) fall = int'(count);
      prev = pwm_out[1];
      @(negedge clk);
      n++;
    end while (count != 0 && n < 1000);
  endtask

  initial begin
    int n, h0, h1, h2, rs, fl, lows;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset pwm_out", int'(pwm_out), 0);
    chk("R11 reset count", int'(count), 0);
    repeat (20) @(negedge clk);
    chk("R6 zero period keeps count at 0", int'(count), 0);
    chk("R9 outputs held low while disabled", int'(pwm_out), 0);
    wr(A_ENA, 7);

    // Table of configurations, each fully committed then measured.
    for (int v = 0; v < 4; v++) begin
      wr(0, VEC[v][0]); wr(1, VEC[v][1]); wr(2, VEC[v][2]); wr(3, VEC[v][3]);
      wr(A_MODE, VEC[v][4]);
      wr(A_LATCH, 15);
      to_zero();
      next_zero();
      measure(n, h0, h1, h2, rs, fl);
      chk($sformatf("R6 period vec%0d", v), n, VEC[v][5]);
      chk($sformatf("R8 ch0 high vec%0d", v), h0, VEC[v][6]);
      chk($sformatf("R8/R7 ch1 high vec%0d", v), h1, VEC[v][7]);
      chk($sformatf("R8/R7 ch2 high vec%0d", v), h2, VEC[v][8]);
    end

    // R1/R5: unrequested writes stay without effect.
    next_zero();
    wr(1, 2);
    wr(0, 3);
    to_zero();
    for (int p = 0; p < 3; p++) begin
      measure(n, h0, h1, h2, rs, fl);
      chk("R5 unrequested slot1 write ignored", h0, 8);
      chk("R1 unrequested slot0 write ignored", n, 8);
    end

    // R3/R2: mid-period request; old value holds, new one starts next period.
    while (count != 2) @(negedge clk);
    wr(1, 4);
    wr(A_LATCH, 2);
    lows = 0;
    while (count != 0) begin
      if (!pwm_out[0]) lows++;
      @(negedge clk);
    end
    chk("R3 old value governs rest of period", lows, 0);
    measure(n, h0, h1, h2, rs, fl);
    chk("R3 new value in first new period", h0, 5);
    chk("R2 unrequested slot0 not committed", n, 8);

    // R4: requests cleared after the commit.
    wr(1, 6);
    next_zero();
    for (int p = 0; p < 2; p++) begin
      measure(n, h0, h1, h2, rs, fl);
      chk("R4 request bits self-cleared", h0, 5);
    end

    // R7: double-edge pair staged in reverse order, committed together.
    wr(0, 15); wr(2, 10); wr(1, 3); wr(A_MODE, 2);
    wr(A_LATCH, 7);
    to_zero();
    next_zero();
    measure(n, h0, h1, h2, rs, fl);
    chk("R7 initial rise position", rs, 4);
    chk("R7 initial fall position", fl, 11);
    wr(2, 12);
    wr(1, 6);
    wr(A_LATCH, 6);
    to_zero();
    measure(n, h0, h1, h2, rs, fl);
    chk("R7 rise moved in first new period", rs, 7);
    chk("R7 fall moved in first new period", fl, 13);
    chk("R7 high width", h1, 6);
    chk("R6 period with top 15", n, 16);

    // R10: request written in the period-event cycle.
    wr(3, 5);
    while (count != 15) @(negedge clk);
    wr(A_LATCH, 8);
    chk("R10 count wrapped on request cycle", int'(count), 0);
    measure(n, h0, h1, h2, rs, fl);
    chk("R10 request on event cycle commits", h2, 6);
    wr(3, 9);
    next_zero();
    measure(n, h0, h1, h2, rs, fl);
    chk("R4 request cleared after event-cycle commit", h2, 6);

    // R9: enable gating and ignored mode bit 0.
    wr(A_ENA, 5);
    wr(A_MODE, 1);
    next_zero();
    next_zero();
    measure(n, h0, h1, h2, rs, fl);
    chk("R9 disabled ch1 stays low", h1, 0);
    chk("R9 mode bit0 ignored, ch0 single-edge", h0, 7);
    chk("R9 enabled ch2 unaffected", h2, 6);
    chk("R6 period unchanged", n, 16);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule